// File: doc/BRIEF.md
# Receive Buffer Credit and Pause Controller

This block keeps, for every pair of DMA channels, a count of the empty receive buffers that software has handed to the hardware. Software raises the count by writing a number into a per-pair allocation register; the DMA lowers it by one for every buffer it fills, signalled by a single-cycle pulse from either channel of the pair. From this count the block derives a pause signal that tells the packet source to hold off when buffers run short.

Pause uses hysteresis. It turns on when the count drops below a programmable low mark and turns off only once the count climbs back to a programmable high mark. A typical setting puts the low mark at a third of the ring and the high mark at two thirds. Each pair has its own enable bit in a shared configuration register. The allocation register also carries an override bit: software sets it while it shuts a channel down, so the pause is held off whatever the count.

Registers are written through a simple write strobe, address and data port. The count and the pause of every pair are visible at the outputs.

Top module: `rxfc_credit_unit`

## Requirements
- R1: Writes are decoded at byte addresses. The configuration register is at 0x00. Pair p has its low mark at 0x04+12p, its high mark at 0x08+12p and its allocation register at 0x0C+12p. A write to any other address changes neither the counts nor the pauses.
- R2: Bit p+1 of the configuration register enables flow control for pair p. Consume pulses from channels 2p and 2p+1 both act on pair p.
- R3: A write to an allocation register with bit 31 clear adds the value in its low CNT_W bits to that pair's count, visible on credit_o at the clock edge that takes the write.
- R4: Each consume pulse lowers the count by one, so two pulses in one cycle lower it by two. The count saturates at zero and at 2^CNT_W-1.
- R5: An allocation and consume pulses in the same cycle give the net sum, clamped once at the end.
- R6: When enabled and not overridden, pause rises when the count falls below the low mark and falls when the count reaches the high mark or more. Between the two marks it keeps its value. Pause changes on the same edge as the count that causes the change.
- R7: While a pair's enable bit is clear, its pause is low and its count still follows allocations and consumes.
- R8: A write to an allocation register with bit 31 set adds nothing and sets that pair's override, which holds pause low. A later allocation write with bit 31 clear removes the override.
- R9: After reset every count, mark, enable and override is zero and every pause is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Byte address of the write |
| reg_wdata_i | input | 32 | Write data |
| buf_used_i | input | 2*NUM_PAIRS | One-cycle pulse per channel: a buffer was consumed |
| pause_o | output | NUM_PAIRS | Backpressure request, one bit per pair |
| credit_o | output | NUM_PAIRS*CNT_W | Current buffer count of each pair, pair 0 lowest |

## Verification
A software allocation and a DMA consume can arrive in the same cycle. The same is true of pulses from both channels of one pair. The bench drives an allocation write together with a consume pulse on one edge and drives both channels of a pair together. It judges the result by the count seen one edge later, which must be the single net sum, and by the pause decision taken on that net value. It also drives a consume into a pair whose count is already zero, to show that the clamp acts once on the combined change.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

   localparam int unsigned CFG_ADDR    = 0;
   localparam int unsigned PAIR_BASE   = 4;
   localparam int unsigned PAIR_STRIDE = 12;
   localparam int unsigned OVR_BIT     = 31;
   localparam int unsigned WDATA_W     = 32;

   typedef enum logic [1:0] {
      FLD_LOW   = 2'd0,
      FLD_HIGH  = 2'd1,
      FLD_ALLOC = 2'd2
   } pair_field_e;

   function automatic int unsigned field_addr(int unsigned pair, pair_field_e fld);
      return PAIR_BASE + PAIR_STRIDE * pair + 4 * int'(fld);
   endfunction

endpackage

// File: rtl/rxfc_reg_decode.sv
module rxfc_reg_decode
   import rxfc_pkg::*;
#(
   parameter int unsigned NUM_PAIRS = 4,
   parameter int unsigned ADDR_W    = 8
) (
   input  logic                 wr_i,
   input  logic [ADDR_W-1:0]    addr_i,
   output logic                 cfg_we_o,
   output logic [NUM_PAIRS-1:0] low_we_o,
   output logic [NUM_PAIRS-1:0] high_we_o,
   output logic [NUM_PAIRS-1:0] alloc_we_o
);

   localparam int unsigned LAST_ADDR = field_addr(NUM_PAIRS - 1, FLD_ALLOC);

   if (LAST_ADDR >= (1 << ADDR_W)) begin : g_addr_chk
      $fatal(1, "ADDR_W too narrow for NUM_PAIRS register map");
   end

   assign cfg_we_o = wr_i && (addr_i == ADDR_W'(CFG_ADDR));

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      localparam logic [ADDR_W-1:0] LOW_A   = ADDR_W'(field_addr(p, FLD_LOW));
      localparam logic [ADDR_W-1:0] HIGH_A  = ADDR_W'(field_addr(p, FLD_HIGH));
      localparam logic [ADDR_W-1:0] ALLOC_A = ADDR_W'(field_addr(p, FLD_ALLOC));
      assign low_we_o[p]   = wr_i && (addr_i == LOW_A);
      assign high_we_o[p]  = wr_i && (addr_i == HIGH_A);
      assign alloc_we_o[p] = wr_i && (addr_i == ALLOC_A);
   end

   always_comb begin
      assert_onehot_strobe_R1 : assert ($onehot0({cfg_we_o, low_we_o, high_we_o, alloc_we_o}))
         else $error("more than one register selected by one write");
   end

endmodule

// File: rtl/rxfc_credit_ctr.sv
module rxfc_credit_ctr #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             add_i,
   input  logic [CNT_W-1:0] add_amt_i,
   input  logic [1:0]       dec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] cnt_next_o
);

   localparam int unsigned EXT_W = CNT_W + 3;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2 || CNT_W > 30) begin : g_w_chk
      $fatal(1, "CNT_W must be in 2..30");
   end

   logic [CNT_W-1:0]        cnt_q;
   logic signed [EXT_W-1:0] net;
   logic [CNT_W-1:0]        amt;

   assign amt = add_i ? add_amt_i : '0;

   always_comb begin
      net = $signed({3'b000, cnt_q}) + $signed({3'b000, amt}) - $signed({{(EXT_W-2){1'b0}}, dec_i});
      if (net < 0)
         cnt_next_o = '0;
      else if (net > $signed({3'b000, CNT_MAX}))
         cnt_next_o = CNT_MAX;
      else
         cnt_next_o = net[CNT_W-1:0];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_next_o;
   end

   assign cnt_o = cnt_q;

   assert_add_exact_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (add_i && dec_i == 2'd0 && ({1'b0, cnt_q} + {1'b0, add_amt_i} <= {1'b0, CNT_MAX}))
      |=> (cnt_q == $past(cnt_q) + $past(add_amt_i)))
      else $error("allocation not added exactly");

   assert_no_underflow_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!add_i && dec_i != 2'd0 && cnt_q == '0) |=> (cnt_q == '0))
      else $error("count wrapped below zero");

   assert_dec_one_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!add_i && dec_i == 2'd1 && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
      else $error("consume did not lower count by one");

   assert_no_overflow_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (add_i && dec_i == 2'd0 && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX))
      else $error("count wrapped above maximum");

endmodule

// File: rtl/rxfc_pause_ctl.sv
module rxfc_pause_ctl #(
   parameter int unsigned CNT_W      = 8,
   parameter bit          HYSTERESIS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             ovr_i,
   input  logic [CNT_W-1:0] low_i,
   input  logic [CNT_W-1:0] high_i,
   input  logic [CNT_W-1:0] cnt_next_i,
   output logic             pause_o
);

   logic pause_q;
   logic pause_d;
   logic active;

   assign active = en_i && !ovr_i;

   if (HYSTERESIS) begin : g_hyst
      always_comb begin
         pause_d = pause_q;
         if (!active)                 pause_d = 1'b0;
         else if (cnt_next_i < low_i) pause_d = 1'b1;
         else if (cnt_next_i >= high_i) pause_d = 1'b0;
      end
   end else begin : g_plain
      logic unused_high;
      assign unused_high = ^high_i;
      always_comb pause_d = active && (cnt_next_i < low_i);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pause_q <= 1'b0;
      else         pause_q <= pause_d;
   end

   assign pause_o = pause_q;

   assert_idle_when_off_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> !pause_o)
      else $error("pause raised while flow control disabled");

   if (HYSTERESIS) begin : g_hyst_chk
      assert_band_hold_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (active && cnt_next_i >= low_i && cnt_next_i < high_i) |=> (pause_o == $past(pause_o)))
         else $error("pause changed inside the hysteresis band");
   end

endmodule

// File: rtl/rxfc_credit_unit.sv
module rxfc_credit_unit
   import rxfc_pkg::*;
#(
   parameter int unsigned NUM_PAIRS  = 4,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned ADDR_W     = 8,
   parameter bit          HYSTERESIS = 1'b1
) (
   input  logic                       clk_i,
   input  logic                       rst_ni,
   input  logic                       reg_wr_i,
   input  logic [ADDR_W-1:0]          reg_addr_i,
   input  logic [31:0]                reg_wdata_i,
   input  logic [2*NUM_PAIRS-1:0]     buf_used_i,
   output logic [NUM_PAIRS-1:0]       pause_o,
   output logic [NUM_PAIRS*CNT_W-1:0] credit_o
);

   localparam int unsigned NUM_CHANS = 2 * NUM_PAIRS;

   if (NUM_PAIRS < 1 || NUM_PAIRS > 30) begin : g_np_chk
      $fatal(1, "NUM_PAIRS must be in 1..30");
   end
   if (NUM_CHANS != 2 * NUM_PAIRS) begin : g_nc_chk
      $fatal(1, "channel count mismatch");
   end

   logic                 cfg_we;
   logic [NUM_PAIRS-1:0] low_we, high_we, alloc_we;
   logic [NUM_PAIRS-1:0] fc_en_q;
   logic                 ovr_set;

   assign ovr_set = reg_wdata_i[OVR_BIT];

   rxfc_reg_decode #(.NUM_PAIRS(NUM_PAIRS), .ADDR_W(ADDR_W)) u_dec (
      .wr_i       (reg_wr_i),
      .addr_i     (reg_addr_i),
      .cfg_we_o   (cfg_we),
      .low_we_o   (low_we),
      .high_we_o  (high_we),
      .alloc_we_o (alloc_we)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     fc_en_q <= '0;
      else if (cfg_we) fc_en_q <= reg_wdata_i[NUM_PAIRS:1];
   end

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      logic [CNT_W-1:0] low_q, high_q;
      logic             ovr_q;
      logic [CNT_W-1:0] cnt, cnt_next;
      logic [1:0]       dec;
      logic             add;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            low_q  <= '0;
            high_q <= '0;
            ovr_q  <= 1'b0;
         end else begin
            if (low_we[p])   low_q  <= reg_wdata_i[CNT_W-1:0];
            if (high_we[p])  high_q <= reg_wdata_i[CNT_W-1:0];
            if (alloc_we[p]) ovr_q  <= ovr_set;
         end
      end

      assign add = alloc_we[p] && !ovr_set;
      assign dec = {1'b0, buf_used_i[2*p]} + {1'b0, buf_used_i[2*p+1]};

      rxfc_credit_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .add_i      (add),
         .add_amt_i  (reg_wdata_i[CNT_W-1:0]),
         .dec_i      (dec),
         .cnt_o      (cnt),
         .cnt_next_o (cnt_next)
      );

      rxfc_pause_ctl #(.CNT_W(CNT_W), .HYSTERESIS(HYSTERESIS)) u_pause (
         .clk_i      (clk_i),
         .rst_ni     (rst_ni),
         .en_i       (fc_en_q[p]),
         .ovr_i      (ovr_q),
         .low_i      (low_q),
         .high_i     (high_q),
         .cnt_next_i (cnt_next),
         .pause_o    (pause_o[p])
      );

      assign credit_o[p*CNT_W +: CNT_W] = cnt;

      assert_override_blocks_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         ovr_q |=> !pause_o[p])
         else $error("pause raised while override set");

      assert_override_no_add_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
         (alloc_we[p] && ovr_set && dec == 2'd0) |=> $stable(cnt))
         else $error("override write changed the count");
   end

endmodule

// File: tb/rxfc_credit_unit_tb_top.sv
module rxfc_credit_unit_tb_top;

   localparam int NP = 4;
   localparam int CW = 8;
   localparam int AW = 8;
   localparam int CMAX = (1 << CW) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr = 1'b0;
   logic [AW-1:0]     addr = '0;
   logic [31:0]       wdata = '0;
   logic [2*NP-1:0]   used = '0;
   logic [NP-1:0]     pause;
   logic [NP*CW-1:0]  credit;

   int errors = 0;
   int checks = 0;
   int m_cred [NP];
   logic [31:0] m_cfg = '0;

   typedef struct {
      int    pair;
      int    cred;
      bit    pz;
      string tag;
   } exp_t;
   exp_t sb_q[$];

   always #4 clk = ~clk;

   rxfc_credit_unit #(.NUM_PAIRS(NP), .CNT_W(CW), .ADDR_W(AW)) dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .reg_wr_i    (wr),
      .reg_addr_i  (addr),
      .reg_wdata_i (wdata),
      .buf_used_i  (used),
      .pause_o     (pause),
      .credit_o    (credit)
   );

   // monitor: pops expected items and compares against the outputs
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         int got;
         e = sb_q.pop_front();
         got = int'(credit[e.pair*CW +: CW]);
         checks++;
         if (got != e.cred || pause[e.pair] !== e.pz) begin
            errors++;
            $display("FAIL %s pair%0d: credit=%0d pause=%b expected credit=%0d pause=%b",
                     e.tag, e.pair, got, pause[e.pair], e.cred, e.pz);
         end
      end
   end

   function automatic int clampc(int v);
      if (v < 0) return 0;
      if (v > CMAX) return CMAX;
      return v;
   endfunction

   function automatic int a_of(int p, int fld);
      return 4 + 12 * p + 4 * fld;
   endfunction

   task automatic expect_st(int p, bit pz, string tag);
      exp_t e;
      e.pair = p; e.cred = m_cred[p]; e.pz = pz; e.tag = tag;
      sb_q.push_back(e);
      wait (sb_q.size() == 0);
   endtask

   // one cycle of stimulus: optional write plus consume pulses
   task automatic step(bit w, int a, logic [31:0] d, logic [2*NP-1:0] u);
      @(negedge clk);
      wr = w; addr = AW'(a); wdata = d; used = u;
      @(negedge clk);
      wr = 1'b0; used = '0;
      for (int p = 0; p < NP; p++) begin
         int add = 0;
         if (w && a == a_of(p, 2) && !d[31]) add = int'(d[CW-1:0]);
         m_cred[p] = clampc(m_cred[p] + add - int'(u[2*p]) - int'(u[2*p+1]));
      end
      if (w && a == 0) m_cfg = d;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
         end
      end
   end

   initial begin
      for (int p = 0; p < NP; p++) m_cred[p] = 0;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R9: reset state
      for (int p = 0; p < NP; p++) expect_st(p, 1'b0, "R9 reset");

      // pair 1: low 3, high 6, enable bit 2
      step(1, a_of(1, 0), 32'd3, '0);
      step(1, a_of(1, 1), 32'd6, '0);
      step(1, 0, 32'h0000_0005, '0);
      idle(2);
      expect_st(1, 1'b1, "R6 below low after enable");
      expect_st(0, 1'b0, "R2 other pair unaffected");

      step(1, a_of(1, 2), 32'd4, '0); idle(1);
      expect_st(1, 1'b1, "R3 add 4, R6 hold in band");
      step(1, a_of(1, 2), 32'd2, '0); idle(1);
      expect_st(1, 1'b0, "R6 release at high");
      step(0, 0, '0, 8'b0000_0100); step(0, 0, '0, 8'b0000_0100); idle(1);
      expect_st(1, 1'b0, "R4 two consumes, R6 hold in band");
      step(0, 0, '0, 8'b0000_1000); idle(1);
      expect_st(1, 1'b0, "R2 odd channel at low mark");
      step(0, 0, '0, 8'b0000_0100); idle(1);
      expect_st(1, 1'b1, "R6 assert below low");
      step(0, 0, '0, 8'b0000_1100); idle(1);
      expect_st(1, 1'b1, "R4 dual consume to zero");
      step(0, 0, '0, 8'b0000_1100); idle(1);
      expect_st(1, 1'b1, "R4 saturate at zero");
      // R5: allocation and consume in the same cycle
      step(1, a_of(1, 2), 32'd5, 8'b0000_0100); idle(1);
      expect_st(1, 1'b1, "R5 net sum 5-1");
      step(1, a_of(1, 2), 32'd7, 8'b0000_1100); idle(1);
      expect_st(1, 1'b0, "R5 net sum 4+7-2");
      step(1, a_of(1, 2), 32'd255, '0); idle(1);
      expect_st(1, 1'b0, "R4 saturate at max");

      // pair 2: override
      step(1, a_of(2, 0), 32'd2, '0);
      step(1, a_of(2, 1), 32'd4, '0);
      step(1, 0, m_cfg | 32'h0000_0008, '0); idle(2);
      expect_st(2, 1'b1, "R2 pair2 enable pauses");
      step(1, a_of(2, 2), 32'h8000_0003, '0); idle(2);
      expect_st(2, 1'b0, "R8 override no add, pause low");
      step(0, 0, '0, 8'b0001_0000); idle(2);
      expect_st(2, 1'b0, "R8 override holds pause low");
      step(1, a_of(2, 2), 32'd1, '0); idle(2);
      expect_st(2, 1'b1, "R8 override cleared by plain alloc");

      // pair 0: disabled, counts still
      step(1, a_of(0, 0), 32'd5, '0);
      step(1, a_of(0, 1), 32'd8, '0);
      step(1, a_of(0, 2), 32'd3, '0); idle(2);
      expect_st(0, 1'b0, "R7 disabled counts, no pause");
      step(0, 0, '0, 8'b0000_0001); idle(2);
      expect_st(0, 1'b0, "R7 disabled consume counted");
      step(1, 0, m_cfg | 32'h0000_0002, '0); idle(2);
      expect_st(0, 1'b1, "R7 enabling pauses below low");

      // R1: unmapped and misaligned addresses have no effect
      step(1, 8'h34, 32'd7, '0);
      step(1, 8'h19, 32'd7, '0);
      step(1, 8'h3C, 32'd7, '0); idle(2);
      for (int p = 0; p < NP; p++) expect_st(p, pause[p], "R1 unmapped write ignored");
      expect_st(3, 1'b0, "R1 pair3 untouched");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule